// File: doc/BRIEF.md
# Configurable Clock Divider Cell

This cell builds one derived clock. It picks either a bypass reference clock or one of up to eight alternate source clocks, divides the picked clock, and drives the result through an optional glitch-free enable gate. The ratio has three possible origins. A fixed divide-by-three path has the highest priority. Next comes a bypass of the programmable divider, which gives divide-by-one. Otherwise a 3-bit code selects a ratio from a short non-linear table.

All control arrives on static configuration pins. The cell registers a new ratio only at the end of the output period that is running, and the division counter restarts from zero at that point. Two build parameters remove the source mux or the gate for instances that do not need them. The cell also returns a logical parent index that tells which source is in use.

Top module: `clkdiv_cell`

## Requirements
- R1: With `src_sw` = 0, the divider runs from `clk_ref` and `src_sel` has no effect. `parent_idx` reads 0.
- R2: With `src_sw` = 1, the divider runs from `clk_alt[src_sel]` and `parent_idx` reads `src_sel` + 1.
- R3: With `div3_sw` = 0 and `div_sw` = 1, the `div_sel` codes 0, 1, 2, 3, 4 and 5 give ratios 1, 2, 4, 6, 8 and 12. Codes 6 and 7 give ratio 1.
- R4: With `div3_sw` = 1, the ratio is 3 for every value of `div_sw` and `div_sel`.
- R5: With `div3_sw` = 0 and `div_sw` = 0, the ratio is 1 and the output follows the source clock.
- R6: For an even ratio N, the output is high for N/2 source periods and low for N/2. For ratio 3, the output is high for one source period and low for two.
- R7: With `clk_en` = 0, `clk_out` stays low. With `clk_en` = 1, the divided clock passes.
- R8: Turning `clk_en` on or off at any phase never produces a shortened high pulse. Each pulse that appears has the full high width for its ratio.
- R9: A ratio change takes effect at the end of the output period that is running. The phase in progress completes with the old ratio, and the new period starts at count zero with its high phase.
- R10: Reset is synchronous and active high. While `rst` is held, the counter is cleared and `clk_out` stays low.
- R11: With `HAS_MUX` = 0, the cell always runs from `clk_ref` and `parent_idx` reads 0. With `HAS_GATE` = 0, the output is always enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Bypass reference clock |
| clk_alt | input | NUM_ALT (8) | Alternate source clocks |
| rst | input | 1 | Synchronous active-high reset |
| src_sw | input | 1 | 0 selects the reference clock, 1 selects an alternate source |
| src_sel | input | 3 | Number of the alternate source |
| div_sw | input | 1 | 0 bypasses the programmable divider |
| div_sel | input | 3 | Code for the table ratio |
| div3_sw | input | 1 | Forces divide-by-three (dominant) |
| clk_en | input | 1 | Output enable |
| clk_out | output | 1 | Divided, gated clock |
| parent_idx | output | IDX_W (4) | 0 for the reference clock, otherwise alternate number + 1 |

## Verification
The bench sweeps every divider code with each switch, and every source with each source switch. It measures period and high time in time units against ratios it computes itself. A wrong table entry, or a divide-by-three that loses priority to the divider switch, shows up as a wrong period. A source mux that still follows `src_sel` while bypassed shows up as a period tied to an alternate clock.

The enable is toggled at phases that keep drifting against the clock. A gate sampled on the wrong edge would then emit short high pulses. A ratio change is applied in the middle of a long high phase. A design that reloads at once would end that phase early, or would start the new period part way through its count.

// File: rtl/clkdiv_cell_pkg.sv
`timescale 1ns/100ps
package clkdiv_cell_pkg;

    localparam int SEL_W   = 3;
    localparam int RATIO_W = 4;

    typedef logic [RATIO_W-1:0] ratio_t;

    // Divider controls gathered into one record.
    typedef struct packed {
        logic             third;   // fixed divide-by-three, dominant
        logic             prog;    // 1 = use the table, 0 = divide by one
        logic [SEL_W-1:0] code;    // table code
    } div_cfg_t;

    function automatic ratio_t table_ratio(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    return ratio_t'(1);
            3'd1:    return ratio_t'(2);
            3'd2:    return ratio_t'(4);
            3'd3:    return ratio_t'(6);
            3'd4:    return ratio_t'(8);
            3'd5:    return ratio_t'(12);
            default: return ratio_t'(1);
        endcase
    endfunction

    function automatic ratio_t pick_ratio(input div_cfg_t c);
        if (c.third)
            return ratio_t'(3);
        else if (!c.prog)
            return ratio_t'(1);
        else
            return table_ratio(c.code);
    endfunction

    // Count values (from zero) during which the divided output is high.
    function automatic ratio_t high_count(input ratio_t r);
        return (r == ratio_t'(3)) ? ratio_t'(1) : (r >> 1);
    endfunction

endpackage

// File: rtl/clkdiv_src_mux.sv
`timescale 1ns/100ps
module clkdiv_src_mux
    import clkdiv_cell_pkg::*;
#(
    parameter int NUM_ALT = 8,
    parameter bit HAS_MUX = 1'b1,
    parameter int IDX_W   = 4
) (
    input  logic               clk_ref,
    input  logic [NUM_ALT-1:0] clk_alt,
    input  logic               src_sw,
    input  logic [SEL_W-1:0]   src_sel,
    output logic               sel_clk,
    output logic [IDX_W-1:0]   parent_idx
);

    generate
        if (HAS_MUX) begin : g_mux
            logic alt_pick;

            always_comb begin
                alt_pick = 1'b0;
                for (int k = 0; k < NUM_ALT; k++) begin
                    if (int'(src_sel) == k)
                        alt_pick = clk_alt[k];
                end
            end

            assign sel_clk    = src_sw ? alt_pick : clk_ref;
            assign parent_idx = src_sw ? (IDX_W'(src_sel) + IDX_W'(1)) : '0;
        end else begin : g_pass
            logic unused_src;
            assign unused_src = ^{clk_alt, src_sw, src_sel};
            assign sel_clk    = clk_ref;
            assign parent_idx = '0;
        end
    endgenerate

endmodule

// File: rtl/clkdiv_ratio_ctr.sv
`timescale 1ns/100ps
module clkdiv_ratio_ctr
    import clkdiv_cell_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t cfg,
    output ratio_t   cnt_q,
    output ratio_t   ratio_q,
    output logic     pre_clk
);

    logic   div_q;
    logic   at_end;
    ratio_t nxt_ratio;
    ratio_t cnt_inc;

    assign nxt_ratio = pick_ratio(cfg);
    assign cnt_inc   = cnt_q + ratio_t'(1);
    // Greater-or-equal keeps the counter bounded even after a clock-mux runt.
    assign at_end    = (cnt_inc >= ratio_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ratio_q <= ratio_t'(1);
            div_q   <= 1'b0;
        end else if (at_end) begin
            cnt_q   <= '0;
            ratio_q <= nxt_ratio;
            div_q   <= (nxt_ratio != ratio_t'(1));
        end else begin
            cnt_q   <= cnt_inc;
            div_q   <= (cnt_inc < high_count(ratio_q));
        end
    end

    // Divide-by-one passes the source clock itself.
    assign pre_clk = (ratio_q == ratio_t'(1)) ? clk : div_q;

endmodule

// File: rtl/clkdiv_out_gate.sv
`timescale 1ns/100ps
module clkdiv_out_gate #(
    parameter bit HAS_GATE = 1'b1
) (
    input  logic clk_in,
    input  logic rst,
    input  logic en,
    output logic en_q,
    output logic clk_out
);

    generate
        if (HAS_GATE) begin : g_gate
            // Enable is taken while the clock is low, so pulses pass whole or not at all.
            always_ff @(negedge clk_in) begin
                if (rst)
                    en_q <= 1'b0;
                else
                    en_q <= en;
            end
            assign clk_out = clk_in & en_q;
        end else begin : g_open
            logic unused_gate;
            assign unused_gate = en ^ rst;
            assign en_q        = 1'b1;
            assign clk_out     = clk_in;
        end
    endgenerate

endmodule

// File: rtl/clkdiv_cell.sv
`timescale 1ns/100ps
module clkdiv_cell
    import clkdiv_cell_pkg::*;
#(
    parameter int NUM_ALT  = 8,
    parameter bit HAS_MUX  = 1'b1,
    parameter bit HAS_GATE = 1'b1,
    parameter int IDX_W    = $clog2(NUM_ALT + 1)
) (
    input  logic               clk_ref,
    input  logic [NUM_ALT-1:0] clk_alt,
    input  logic               rst,
    input  logic               src_sw,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               div_sw,
    input  logic [SEL_W-1:0]   div_sel,
    input  logic               div3_sw,
    input  logic               clk_en,
    output logic               clk_out,
    output logic [IDX_W-1:0]   parent_idx
);

    logic     sel_clk;
    logic     pre_clk;
    logic     en_q;
    ratio_t   cnt_q;
    ratio_t   ratio_q;
    div_cfg_t div_cfg;

    assign div_cfg = '{third: div3_sw, prog: div_sw, code: div_sel};

    clkdiv_src_mux #(
        .NUM_ALT (NUM_ALT),
        .HAS_MUX (HAS_MUX),
        .IDX_W   (IDX_W)
    ) u_src (
        .clk_ref    (clk_ref),
        .clk_alt    (clk_alt),
        .src_sw     (src_sw),
        .src_sel    (src_sel),
        .sel_clk    (sel_clk),
        .parent_idx (parent_idx)
    );

    clkdiv_ratio_ctr u_ctr (
        .clk     (sel_clk),
        .rst     (rst),
        .cfg     (div_cfg),
        .cnt_q   (cnt_q),
        .ratio_q (ratio_q),
        .pre_clk (pre_clk)
    );

    clkdiv_out_gate #(
        .HAS_GATE (HAS_GATE)
    ) u_gate (
        .clk_in  (pre_clk),
        .rst     (rst),
        .en      (clk_en),
        .en_q    (en_q),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/clkdiv_cell_chk.sv
`timescale 1ns/100ps
module clkdiv_cell_chk
    import clkdiv_cell_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   third,
    input ratio_t cnt_q,
    input ratio_t ratio_q,
    input logic   en_q,
    input logic   clk_out
);

    p_ratio_legal_r3: assert property (@(posedge clk) disable iff (rst)
        ratio_q inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12});

    p_third_wins_r4: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q + 4'd1 == ratio_q) && third) |=> (ratio_q == 4'd3));

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q < ratio_q);

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q + 4'd1 == ratio_q) |=> (cnt_q == 4'd0));

    p_ratio_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q + 4'd1 != ratio_q) |=> $stable(ratio_q));

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cnt_q == 4'd0));

    p_gate_low_r7: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !clk_out);

endmodule

bind clkdiv_cell clkdiv_cell_chk u_chk (
    .clk     (sel_clk),
    .rst     (rst),
    .third   (div3_sw),
    .cnt_q   (cnt_q),
    .ratio_q (ratio_q),
    .en_q    (en_q),
    .clk_out (clk_out)
);

// File: tb/sim_clkdiv_cell.sv
`timescale 1ns/100ps
module sim_clkdiv_cell;

    localparam int REF_PERIOD  = 10;
    localparam int ALT_HALF0   = 6;       // alternate k has period 2*(ALT_HALF0+k)
    localparam int LIMIT       = 3000;
    localparam int WATCHDOG_NS = 400000;

    logic       clk_ref;
    logic [7:0] clk_alt;
    logic       rst, src_sw, div_sw, div3_sw, clk_en;
    logic [2:0] src_sel, div_sel;
    logic       out0, out1;
    logic [3:0] idx0, idx1;
    int         which;
    logic       probe;
    int         n_chk, n_bad;
    bit         done;

    initial clk_ref = 1'b0;
    always #(REF_PERIOD / 2) clk_ref = ~clk_ref;

    for (genvar k = 0; k < 8; k++) begin : g_alt
        logic c;
        initial c = 1'b0;
        always #(ALT_HALF0 + k) c = ~c;
        assign clk_alt[k] = c;
    end

    clkdiv_cell u0 (
        .clk_ref(clk_ref), .clk_alt(clk_alt), .rst(rst),
        .src_sw(src_sw), .src_sel(src_sel), .div_sw(div_sw),
        .div_sel(div_sel), .div3_sw(div3_sw), .clk_en(clk_en),
        .clk_out(out0), .parent_idx(idx0)
    );

    clkdiv_cell #(.HAS_MUX(1'b0), .HAS_GATE(1'b0)) u1 (
        .clk_ref(clk_ref), .clk_alt(clk_alt), .rst(rst),
        .src_sw(src_sw), .src_sel(src_sel), .div_sw(div_sw),
        .div_sel(div_sel), .div3_sw(div3_sw), .clk_en(clk_en),
        .clk_out(out1), .parent_idx(idx1)
    );

    assign probe = (which == 1) ? out1 : out0;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic ssw, input logic [2:0] ssel, input logic dsw,
                           input logic [2:0] dsel, input logic d3, input logic en);
        src_sw = ssw; src_sel = ssel; div_sw = dsw;
        div_sel = dsel; div3_sw = d3; clk_en = en;
    endtask

    task automatic wait_lvl(input logic lvl, output int t, output bit ok);
        int n;
        n = 0;
        while (probe == lvl && n < LIMIT) begin #1; n++; end
        while (probe != lvl && n < LIMIT) begin #1; n++; end
        ok = (n < LIMIT);
        t  = int'($realtime);
    endtask

    task automatic measure(output int per, output int hi);
        int t0, tf, t1;
        bit ok, a;
        ok = 1'b1;
        repeat (3) begin wait_lvl(1'b1, t0, a); ok &= a; end
        wait_lvl(1'b0, tf, a); ok &= a;
        wait_lvl(1'b1, t1, a); ok &= a;
        if (ok) begin per = t1 - t0; hi = tf - t0; end
        else    begin per = -1;      hi = -1;      end
    endtask

    task automatic runt_scan(input int full, input int toggle, output int runts,
                             output int pulses);
        int run;
        run = 0; runts = 0; pulses = 0;
        for (int i = 0; i < 900; i++) begin
            #1;
            if (i % toggle == toggle - 1) clk_en = ~clk_en;
            if (probe) run++;
            else if (run > 0) begin
                pulses++;
                if (run != full) runts++;
                run = 0;
            end
        end
    endtask

    function automatic int exp_table(input int code);
        case (code)
            0: return 1;  1: return 2;  2: return 4;
            3: return 6;  4: return 8;  5: return 12;
            default: return 1;
        endcase
    endfunction

    initial begin
        #(WATCHDOG_NS);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int per, hi, highs, runts, pulses, t0, tf, t1, t2;
        bit a;
        n_chk = 0; n_bad = 0; done = 1'b0; which = 0;
        rst = 1'b1;
        set_cfg(1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1);
        #0.5;
        #200;

        // R10: output held low during reset
        highs = 0;
        repeat (60) begin #1; if (probe) highs++; end
        check_eq("R10 low in reset", highs, 0);
        rst = 1'b0;
        #100;

        // R5: divider bypass, every code gives the source clock
        for (int c = 0; c < 8; c++) begin
            set_cfg(1'b0, 3'd0, 1'b0, 3'(c), 1'b0, 1'b1);
            measure(per, hi);
            check_eq("R5 period", per, REF_PERIOD);
            check_eq("R5 high", hi, REF_PERIOD / 2);
        end

        // R3/R6: table sweep
        for (int c = 0; c < 8; c++) begin
            int r;
            r = exp_table(c);
            set_cfg(1'b0, 3'd0, 1'b1, 3'(c), 1'b0, 1'b1);
            measure(per, hi);
            check_eq("R3 period", per, r * REF_PERIOD);
            check_eq("R6 high even", hi, (r == 1) ? REF_PERIOD / 2 : r * REF_PERIOD / 2);
        end

        // R4/R6: divide-by-three dominates both divider controls
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 8; c++) begin
                set_cfg(1'b0, 3'd0, 1'(s), 3'(c), 1'b1, 1'b1);
                measure(per, hi);
                check_eq("R4 period", per, 3 * REF_PERIOD);
                check_eq("R6 high third", hi, REF_PERIOD);
            end
        end

        // R1: bypass source ignores src_sel
        for (int s = 0; s < 8; s++) begin
            set_cfg(1'b0, 3'(s), 1'b1, 3'd1, 1'b0, 1'b1);
            measure(per, hi);
            check_eq("R1 period", per, 2 * REF_PERIOD);
            check_eq("R1 idx", int'(idx0), 0);
        end

        // R2: alternate sources
        for (int s = 0; s < 8; s++) begin
            set_cfg(1'b1, 3'(s), 1'b1, 3'd1, 1'b0, 1'b1);
            measure(per, hi);
            check_eq("R2 period", per, 4 * (ALT_HALF0 + s));
            check_eq("R2 idx", int'(idx0), s + 1);
        end

        // R7: enable low holds output low, then passes again
        set_cfg(1'b0, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0);
        #50;
        highs = 0;
        repeat (400) begin #1; if (probe) highs++; end
        check_eq("R7 gated low", highs, 0);
        clk_en = 1'b1;
        measure(per, hi);
        check_eq("R7 passes", per, 2 * REF_PERIOD);

        // R8: enable toggled at drifting phases
        set_cfg(1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0);
        #40;
        runt_scan(REF_PERIOD / 2, 13, runts, pulses);
        check_eq("R8 runts ratio1", runts, 0);
        check_eq("R8 pulses ratio1", int'(pulses > 0), 1);
        set_cfg(1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0);
        #100;
        runt_scan(REF_PERIOD, 37, runts, pulses);
        check_eq("R8 runts ratio3", runts, 0);
        check_eq("R8 pulses ratio3", int'(pulses > 0), 1);

        // R9: change from 12 to 2 during the high phase
        set_cfg(1'b0, 3'd0, 1'b1, 3'd5, 1'b0, 1'b1);
        measure(per, hi);
        check_eq("R9 start ratio", per, 12 * REF_PERIOD);
        wait_lvl(1'b1, t0, a);
        #20;
        div_sel = 3'd1;
        wait_lvl(1'b0, tf, a);
        check_eq("R9 old high kept", tf - t0, 6 * REF_PERIOD);
        wait_lvl(1'b1, t1, a);
        check_eq("R9 old period kept", t1 - t0, 12 * REF_PERIOD);
        wait_lvl(1'b0, tf, a);
        check_eq("R9 new high", tf - t1, REF_PERIOD);
        wait_lvl(1'b1, t2, a);
        check_eq("R9 new period", t2 - t1, 2 * REF_PERIOD);

        // R11: instance without mux and gate
        which = 1;
        set_cfg(1'b1, 3'd5, 1'b1, 3'd2, 1'b0, 1'b0);
        measure(per, hi);
        check_eq("R11 no mux period", per, 4 * REF_PERIOD);
        check_eq("R11 no gate high", hi, 2 * REF_PERIOD);
        check_eq("R11 idx", int'(idx1), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule